// File: doc/BRIEF.md
# Sixteen-Bit Timer with Clear-on-Compare

This block is a 16-bit timer/counter that advances on cycles where a timer-clock enable is high. A four-bit mode code picks how it counts. In free-running mode the counter runs upward and rolls over from all ones to zero. In the two clear-on-compare modes it returns to zero after reaching a top value. Mode 4 takes the top from compare register 0. Mode 12 takes it from a separate capture register. Every other code behaves as free-running mode.

Each compare channel holds a compare value and a two-bit output action. When the counter equals the compare value on an advancing cycle, the channel sets a sticky match flag and applies its action to a waveform output. A force strobe applies the same action at once, without a real match. An overflow flag is set whenever the counter rolls over from all ones. Software clears it with a clear strobe, or an interrupt controller clears it with an acknowledge.

Software may load the counter at any time. A load takes priority over counting and suppresses any compare match in that cycle. All writes go through plain write strobes and take effect at the next clock edge.

Top module: `ctc_timer16`

## Requirements
- R1: After reset the counter, the overflow flag, every match flag and every waveform output are 0. Every compare value, the capture value and every output action (none) are also 0.
- R2: The counter changes only on cycles where tickEn is 1 or cntWrEn is 1. For every mode code other than 4 and 12, each advancing cycle adds one, rolls over from 0xFFFF to 0x0000, and never clears the counter at a compare value.
- R3: On an advancing cycle with the counter at 0xFFFF, the overflow flag is set at the same edge where the counter becomes 0, in any mode. Hardware only sets the flag. ovfClr or ovfAck clears it, and a set in the same cycle wins.
- R4: With modeSel = 4, an advancing cycle with the counter equal to compare value 0 loads 0 instead of incrementing.
- R5: With modeSel = 12, an advancing cycle with the counter equal to the capture value loads 0. Compare value 0 then does not clear the counter.
- R6: On an advancing cycle with the counter equal to a channel's compare value, that channel's match flag is set at the next edge. Only cmpFlagClr clears it, and a set in the same cycle wins.
- R7: On a match, the channel's action code changes its waveform output at that edge: 00 leaves it, 01 inverts it, 10 drives it to 0, 11 drives it to 1.
- R8: Writing an output action does not change the waveform output. The new code is used at the first match or force after the write edge, and a match in the same cycle as the write uses the old code.
- R9: A force strobe applies the channel's current action at the next edge. It sets no match flag and does not change the counter.
- R10: A counter write loads cntWrData at the next edge, overrides counting and clearing, and suppresses matches and overflow in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer-clock enable; the counter advances when high |
| modeSel | input | 4 | Mode code: 4 = clear at compare 0, 12 = clear at capture value, other = free-running |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | W | Counter write value |
| cmpWrEn | input | NUM_CH | Compare value write strobe, one per channel |
| cmpWrData | input | W | Compare write value (shared) |
| capWrEn | input | 1 | Capture register write strobe |
| capWrData | input | W | Capture register write value |
| actWrEn | input | NUM_CH | Output action write strobe, one per channel |
| actWrData | input | 2 | Output action code (shared) |
| forceStb | input | NUM_CH | Force-compare strobe, one per channel |
| ovfClr | input | 1 | Software clear of the overflow flag |
| ovfAck | input | 1 | Interrupt acknowledge, clears the overflow flag |
| cmpFlagClr | input | NUM_CH | Software clear of the match flags |
| cntOut | output | W | Counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpFlag | output | NUM_CH | Sticky match flags |
| wavOut | output | NUM_CH | Waveform outputs |

## Verification
The bench sweeps every top value from 0 to 7 in both clear-on-compare modes. A design that picked the wrong top source, or cleared one count early or late, would show a short or long period. It loads the counter above the top value to check the run up to 0xFFFF and the rollover. It also checks that a clear strobe landing on the same cycle as a set cannot hide an overflow or a match. It crosses every action code with every channel, with force strobes and action writes placed next to matches, so an action applied at write time, or a force that sets a flag, shows at once. A counter load on a matching cycle must produce no flag, which catches a design that compares before giving the write priority.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } outAct_e;

  typedef enum logic [1:0] {
    TOP_MAX = 2'd0,
    TOP_CMP = 2'd1,
    TOP_CAP = 2'd2
  } topSrc_e;

  localparam logic [3:0] MODE_CTC_CMP = 4'd4;
  localparam logic [3:0] MODE_CTC_CAP = 4'd12;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic load;    // software counter write
    logic wrap;    // clear to zero at top
    logic inc;     // advance by one
    logic ovfSet;  // roll over from all ones
  } cntStb_t;

  function automatic logic applyAct(input outAct_e act, input logic cur);
    case (act)
      ACT_TOGGLE: applyAct = ~cur;
      ACT_CLEAR:  applyAct = 1'b0;
      ACT_SET:    applyAct = 1'b1;
      default:    applyAct = cur;
    endcase
  endfunction

endpackage

// File: rtl/timer16_dp.sv
module timer16_dp
  import timer16_pkg::*;
#(
  parameter int W      = 16,
  parameter int NUM_CH = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cntStb_t                      stb,
  input  logic [W-1:0]                 cntWrData,
  input  logic [NUM_CH-1:0]            cmpWrEn,
  input  logic [W-1:0]                 cmpWrData,
  input  logic                         capWrEn,
  input  logic [W-1:0]                 capWrData,
  input  logic                         ovfClr,
  input  logic                         ovfAck,
  output logic [W-1:0]                 cntVal,
  output logic [NUM_CH-1:0][W-1:0]     cmpVals,
  output logic [W-1:0]                 capVal,
  output logic                         ovfFlag
);

  logic [W-1:0] cntNext;

  always_comb begin
    cntNext = cntVal;
    if (stb.load)      cntNext = cntWrData;
    else if (stb.wrap) cntNext = '0;
    else if (stb.inc)  cntNext = cntVal + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntVal <= '0;
    else       cntVal <= cntNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 ovfFlag <= 1'b0;
    else if (stb.ovfSet)       ovfFlag <= 1'b1;
    else if (ovfClr || ovfAck) ovfFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        capVal <= '0;
    else if (capWrEn) capVal <= capWrData;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmpReg
    always_ff @(posedge clk) begin
      if (!rstN)           cmpVals[i] <= '0;
      else if (cmpWrEn[i]) cmpVals[i] <= cmpWrData;
    end
  end

endmodule

// File: rtl/timer16_ctrl.sv
module timer16_ctrl
  import timer16_pkg::*;
#(
  parameter int W      = 16,
  parameter int NUM_CH = 2
) (
  input  logic                     tickEn,
  input  logic [3:0]               modeSel,
  input  logic                     cntWrEn,
  input  logic [W-1:0]             cntVal,
  input  logic [NUM_CH-1:0][W-1:0] cmpVals,
  input  logic [W-1:0]             capVal,
  output cntStb_t                  stb,
  output logic [NUM_CH-1:0]        matchHit
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  topSrc_e      topSrc;
  logic [W-1:0] topVal;
  logic         advance;
  logic         atTop;

  always_comb begin
    case (modeSel)
      MODE_CTC_CMP: topSrc = TOP_CMP;
      MODE_CTC_CAP: topSrc = TOP_CAP;
      default:      topSrc = TOP_MAX;
    endcase
  end

  always_comb begin
    case (topSrc)
      TOP_CMP: topVal = cmpVals[0];
      TOP_CAP: topVal = capVal;
      default: topVal = MAXV;
    endcase
  end

  assign advance = tickEn & ~cntWrEn;
  assign atTop   = (topSrc != TOP_MAX) && (cntVal == topVal);

  always_comb begin
    stb        = '0;
    stb.load   = cntWrEn;
    stb.inc    = advance;
    stb.wrap   = advance & atTop;
    stb.ovfSet = advance & (cntVal == MAXV);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_match
    assign matchHit[i] = advance && (cntVal == cmpVals[i]);
  end

endmodule

// File: rtl/timer16_och.sv
module timer16_och
  import timer16_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       matchHit,
  input  logic       forceStb,
  input  logic       actWrEn,
  input  logic [1:0] actWrData,
  input  logic       flagClr,
  output logic       cmpFlag,
  output logic       wavOut
);

  outAct_e actReg;

  always_ff @(posedge clk) begin
    if (!rstN)        actReg <= ACT_NONE;
    else if (actWrEn) actReg <= outAct_e'(actWrData);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     wavOut <= 1'b0;
    else if (matchHit || forceStb) wavOut <= applyAct(actReg, wavOut);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         cmpFlag <= 1'b0;
    else if (matchHit) cmpFlag <= 1'b1;
    else if (flagClr)  cmpFlag <= 1'b0;
  end

endmodule

// File: rtl/ctc_timer16.sv
module ctc_timer16
  import timer16_pkg::*;
#(
  parameter int W      = 16,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [3:0]        modeSel,
  input  logic              cntWrEn,
  input  logic [W-1:0]      cntWrData,
  input  logic [NUM_CH-1:0] cmpWrEn,
  input  logic [W-1:0]      cmpWrData,
  input  logic              capWrEn,
  input  logic [W-1:0]      capWrData,
  input  logic [NUM_CH-1:0] actWrEn,
  input  logic [1:0]        actWrData,
  input  logic [NUM_CH-1:0] forceStb,
  input  logic              ovfClr,
  input  logic              ovfAck,
  input  logic [NUM_CH-1:0] cmpFlagClr,
  output logic [W-1:0]      cntOut,
  output logic              ovfFlag,
  output logic [NUM_CH-1:0] cmpFlag,
  output logic [NUM_CH-1:0] wavOut
);

  cntStb_t                  stb;
  logic [NUM_CH-1:0]        matchHit;
  logic [NUM_CH-1:0][W-1:0] cmpVals;
  logic [W-1:0]             capVal;

  timer16_ctrl #(.W(W), .NUM_CH(NUM_CH)) ctrl_i (
    .tickEn   (tickEn),
    .modeSel  (modeSel),
    .cntWrEn  (cntWrEn),
    .cntVal   (cntOut),
    .cmpVals  (cmpVals),
    .capVal   (capVal),
    .stb      (stb),
    .matchHit (matchHit)
  );

  timer16_dp #(.W(W), .NUM_CH(NUM_CH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cntWrData (cntWrData),
    .cmpWrEn   (cmpWrEn),
    .cmpWrData (cmpWrData),
    .capWrEn   (capWrEn),
    .capWrData (capWrData),
    .ovfClr    (ovfClr),
    .ovfAck    (ovfAck),
    .cntVal    (cntOut),
    .cmpVals   (cmpVals),
    .capVal    (capVal),
    .ovfFlag   (ovfFlag)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    timer16_och och_i (
      .clk       (clk),
      .rstN      (rstN),
      .matchHit  (matchHit[i]),
      .forceStb  (forceStb[i]),
      .actWrEn   (actWrEn[i]),
      .actWrData (actWrData),
      .flagClr   (cmpFlagClr[i]),
      .cmpFlag   (cmpFlag[i]),
      .wavOut    (wavOut[i])
    );
  end

endmodule

// File: rtl/ctc_timer16_chk.sv
module ctc_timer16_chk #(
  parameter int W      = 16,
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [3:0]        modeSel,
  input logic              cntWrEn,
  input logic [W-1:0]      cntWrData,
  input logic [NUM_CH-1:0] cmpWrEn,
  input logic [W-1:0]      cmpWrData,
  input logic              capWrEn,
  input logic [W-1:0]      capWrData,
  input logic [NUM_CH-1:0] forceStb,
  input logic              ovfClr,
  input logic              ovfAck,
  input logic [NUM_CH-1:0] cmpFlagClr,
  input logic [W-1:0]      cntOut,
  input logic              ovfFlag,
  input logic [NUM_CH-1:0] cmpFlag,
  input logic [NUM_CH-1:0] wavOut
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  // Shadow copies of software-written values, recorded from the write strobes
  logic [NUM_CH-1:0][W-1:0] shCmp;
  logic [W-1:0]             shCap;
  logic [NUM_CH-1:0]        matchNow;

  always_ff @(posedge clk) begin
    if (!rstN)        shCap <= '0;
    else if (capWrEn) shCap <= capWrData;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sh
    always_ff @(posedge clk) begin
      if (!rstN)           shCmp[i] <= '0;
      else if (cmpWrEn[i]) shCmp[i] <= cmpWrData;
    end
    assign matchNow[i] = tickEn && !cntWrEn && (cntOut == shCmp[i]);
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn && !cntWrEn |=> $stable(cntOut));

  // R2
  free_run_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && !cntWrEn && modeSel == 4'd0 |=> cntOut == W'($past(cntOut) + 1'b1));

  // R10
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> cntOut == $past(cntWrData));

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && !cntWrEn && cntOut == MAXV |=> ovfFlag && cntOut == '0);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !ovfClr && !ovfAck |=> ovfFlag);

  // R4
  top_cmp_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == 4'd4 && matchNow[0] |=> cntOut == '0);

  // R5
  top_cap_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == 4'd12 && tickEn && !cntWrEn && cntOut == shCap |=> cntOut == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      matchNow[i] |=> cmpFlag[i]);
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      cmpFlag[i] && !cmpFlagClr[i] |=> cmpFlag[i]);
    // R8
    wav_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !matchNow[i] && !forceStb[i] |=> $stable(wavOut[i]));
    // R9
    force_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      forceStb[i] && !matchNow[i] && !cmpFlag[i] |=> !cmpFlag[i]);
  end

endmodule

bind ctc_timer16 ctc_timer16_chk #(.W(W), .NUM_CH(NUM_CH)) chk_i (.*);

// File: tb/ctc_timer16_tb_top.sv
module ctc_timer16_tb_top;

  localparam int W  = 16;
  localparam int NC = 2;
  localparam logic [W-1:0] MAXV = 16'hFFFF;

  logic          clk = 1'b0;
  logic          rstN;
  logic          tickEn;
  logic [3:0]    modeSel;
  logic          cntWrEn;
  logic [W-1:0]  cntWrData;
  logic [NC-1:0] cmpWrEn;
  logic [W-1:0]  cmpWrData;
  logic          capWrEn;
  logic [W-1:0]  capWrData;
  logic [NC-1:0] actWrEn;
  logic [1:0]    actWrData;
  logic [NC-1:0] forceStb;
  logic          ovfClr;
  logic          ovfAck;
  logic [NC-1:0] cmpFlagClr;
  logic [W-1:0]  cntOut;
  logic          ovfFlag;
  logic [NC-1:0] cmpFlag;
  logic [NC-1:0] wavOut;

  always #4 clk = ~clk;

  ctc_timer16 #(.W(W), .NUM_CH(NC)) dut_i (.*);

  // Reference state built from the requirements
  logic [W-1:0]  mCnt;
  logic          mOvf;
  logic [NC-1:0] mFlag;
  logic [NC-1:0] mWav;
  logic [1:0]    mAct [NC];
  logic [W-1:0]  mCmp [NC];
  logic [W-1:0]  mCap;

  int  nVec = 0;
  int  nBad = 0;
  bit  done = 1'b0;

  task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "cntOut", cntOut, mCnt);
    chk(tag, "ovfFlag", W'(ovfFlag), W'(mOvf));
    chk(tag, "cmpFlag", W'(cmpFlag), W'(mFlag));
    chk(tag, "wavOut", W'(wavOut), W'(mWav));
  endtask

  // One clock: update the reference from the driven inputs, pass an edge, compare
  task automatic step(input string tag);
    logic          adv;
    logic          ctc;
    logic [W-1:0]  top;
    logic [NC-1:0] hit;
    adv = tickEn && !cntWrEn;
    ctc = (modeSel == 4'd4) || (modeSel == 4'd12);
    top = (modeSel == 4'd4) ? mCmp[0] : mCap;
    for (int i = 0; i < NC; i++) hit[i] = adv && (mCnt == mCmp[i]);
    if (adv && mCnt == MAXV)   mOvf = 1'b1;
    else if (ovfClr || ovfAck) mOvf = 1'b0;
    for (int i = 0; i < NC; i++) begin
      if (hit[i])             mFlag[i] = 1'b1;
      else if (cmpFlagClr[i]) mFlag[i] = 1'b0;
      if (hit[i] || forceStb[i]) begin
        case (mAct[i])
          2'b01:   mWav[i] = ~mWav[i];
          2'b10:   mWav[i] = 1'b0;
          2'b11:   mWav[i] = 1'b1;
          default: mWav[i] = mWav[i];
        endcase
      end
    end
    if (cntWrEn)  mCnt = cntWrData;
    else if (adv) mCnt = (ctc && mCnt == top) ? '0 : mCnt + 1'b1;
    for (int i = 0; i < NC; i++) begin
      if (cmpWrEn[i]) mCmp[i] = cmpWrData;
      if (actWrEn[i]) mAct[i] = actWrData;
    end
    if (capWrEn) mCap = capWrData;
    @(negedge clk);
    cntWrEn = 1'b0; cmpWrEn = '0; capWrEn = 1'b0; actWrEn = '0;
    forceStb = '0; ovfClr = 1'b0; ovfAck = 1'b0; cmpFlagClr = '0;
    compareAll(tag);
  endtask

  task automatic setCnt(input logic [W-1:0] v);
    logic t;
    t = tickEn; tickEn = 1'b0;
    cntWrEn = 1'b1; cntWrData = v; step("R10");
    tickEn = t;
  endtask

  task automatic setCmp(input int ch, input logic [W-1:0] v);
    cmpWrEn[ch] = 1'b1; cmpWrData = v; step("R6");
  endtask

  task automatic setCap(input logic [W-1:0] v);
    capWrEn = 1'b1; capWrData = v; step("R5");
  endtask

  task automatic setAct(input int ch, input logic [1:0] a);
    actWrEn[ch] = 1'b1; actWrData = a; step("R8");
  endtask

  // pat 0: tick every cycle; pat 1: tick on two of every three cycles
  task automatic run(input int n, input int pat, input string tag);
    for (int k = 0; k < n; k++) begin
      tickEn = (pat == 0) ? 1'b1 : ((k % 3) != 1);
      step(tag);
    end
    tickEn = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b0; modeSel = 4'd0;
    cntWrEn = 1'b0; cntWrData = '0; cmpWrEn = '0; cmpWrData = '0;
    capWrEn = 1'b0; capWrData = '0; actWrEn = '0; actWrData = '0;
    forceStb = '0; ovfClr = 1'b0; ovfAck = 1'b0; cmpFlagClr = '0;
    mCnt = '0; mOvf = 1'b0; mFlag = '0; mWav = '0; mCap = '0;
    for (int i = 0; i < NC; i++) begin mAct[i] = 2'b00; mCmp[i] = '0; end
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");
    // R1: all stored values are zero, so a tick from 0 matches both channels
    tickEn = 1'b1; step("R1");
    tickEn = 1'b0; cmpFlagClr = '1; step("R6");

    // R2, R3: free-running rollover with an irregular tick pattern
    setAct(0, 2'b01);
    setCmp(0, 16'hFFF8);
    setCmp(1, 16'h0003);
    setCnt(16'hFFF0);
    run(40, 1, "R2");
    run(6, 0, "R2");

    // R3: flag clear and acknowledge, set wins over a same-cycle clear
    setCnt(MAXV);
    tickEn = 1'b1; ovfClr = 1'b1; step("R3");
    tickEn = 1'b0; ovfAck = 1'b1; step("R3");
    setCnt(MAXV);
    tickEn = 1'b1; ovfAck = 1'b1; step("R3");
    tickEn = 1'b0; ovfClr = 1'b1; step("R3");
    step("R3");

    // R4: clear at compare value 0, every top from 0 to 7
    setAct(1, 2'b01);
    for (int t = 0; t < 8; t++) begin
      modeSel = 4'd4;
      setCmp(0, W'(t));
      setCmp(1, W'(t / 2));
      setCnt('0);
      run(3 * (t + 1) + 2, t % 2, "R4");
    end

    // R5: clear at the capture value; compare 0 lies below it and must not clear
    for (int t = 0; t < 8; t++) begin
      modeSel = 4'd12;
      setCap(W'(t));
      setCmp(0, W'(t / 3));
      setCnt('0);
      run(3 * (t + 1) + 2, 0, "R5");
    end

    // R4, R3: counter loaded above the top runs to all ones and rolls over
    modeSel = 4'd4;
    setCmp(0, 16'h0005);
    setCnt(16'hFFFD);
    run(14, 0, "R4");

    // R2: other mode codes count freely through the compare value
    for (int m = 1; m < 16; m += 4) begin
      modeSel = 4'(m);
      setCmp(0, 16'h0003);
      setCnt('0);
      run(8, 0, "R2");
    end
    modeSel = 4'd13; setCnt('0); run(6, 0, "R2");

    // R7, R8, R9: every action code on every channel, forced and matched
    modeSel = 4'd0;
    for (int a = 0; a < 4; a++) begin
      for (int ch = 0; ch < NC; ch++) begin
        setCmp(ch, W'(16'h0040 + ch));
        setCnt(16'h003E);
        setAct(ch, 2'(a));
        forceStb[ch] = 1'b1; step("R9");
        forceStb[ch] = 1'b1; step("R9");
        cmpFlagClr = '1; step("R6");
        run(4, 0, "R7");
        forceStb[ch] = 1'b1; tickEn = 1'b1; step("R9");
        tickEn = 1'b0;
      end
    end

    // R8: action written in the cycle of a match uses the old code
    setAct(0, 2'b11);
    setCmp(0, 16'h0080);
    setCnt(16'h0080);
    tickEn = 1'b1; actWrEn[0] = 1'b1; actWrData = 2'b10; step("R8");
    tickEn = 1'b0;
    setCnt(16'h0080);
    tickEn = 1'b1; step("R8");
    tickEn = 1'b0;

    // R10: counter write on a matching cycle suppresses the match and overflow
    cmpFlagClr = '1; step("R6");
    setCmp(0, MAXV);
    setCnt(MAXV);
    tickEn = 1'b1; cntWrEn = 1'b1; cntWrData = 16'h1234; step("R10");
    tickEn = 1'b0; step("R10");

    // R6: flag set wins over a same-cycle clear, then a lone clear drops it
    setCmp(0, 16'h0100);
    setCnt(16'h0100);
    tickEn = 1'b1; cmpFlagClr[0] = 1'b1; step("R6");
    tickEn = 1'b0; cmpFlagClr[0] = 1'b1; step("R6");
    step("R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule